// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block holds a wall-clock calendar made of seconds, minutes, hours, day of week, day of month, month and a two-digit year. Each accepted one-second strobe moves it forward by one second. Carries ripple through the fields: day of month, then month, then year. Month lengths follow the Gregorian rules, including the century exception and its 400-year override. The leap decision needs the full year, so an internal century counter runs beside the two-digit year. It starts at a parameter value and steps whenever the year wraps from 99 to 00.

The fields are presented in register format. The host picks the format with two mode inputs: BCD or plain binary, and 24-hour or 12-hour with an afternoon flag in bit 7 of the hour. A strobe only counts while the three-bit divider-select input holds the run code. When a strobe is accepted, an update-in-progress window opens first and the registers change at its end. A single-cycle done strobe then tells the alarm and status logic that fresh values are in place.

To set the clock, the host raises the halt input. While halt is high, writes go straight into the field registers and strobes are ignored. When halt falls, the written values are decoded in the current format and loaded into the counter.

Top module: `rtc_calendar_counter`

## Requirements
- R1: After a synchronous reset every field reads midnight on day 1 of month 1, year 00, with day of week 1. Midnight reads 0x00 in 24-hour mode, 0x12 in 12-hour BCD mode and 0x0C in 12-hour binary mode. Both the window and the done strobe are low.
- R2: Seconds and minutes wrap from 59 to 0 and carry. Hours wrap from 23 to 0 and carry into the day. Day of week runs 1 to 7 and returns to 1 on each new day.
- R3: Month lengths are 31 for months 1, 3, 5, 7, 8, 10 and 12, and 30 for months 4, 6, 9 and 11. February has 29 days when the full year (century*100 + year) is divisible by 4, unless it is divisible by 100 but not by 400; otherwise it has 28. The century starts at RESET_CENTURY (20) and advances when the year wraps.
- R4: A day of month past the month length returns to 1 and advances the month. Month 12 returns to 1 and advances the year. The year wraps from 99 to 00.
- R5: With bcd_mode_i=1 a field holds its tens digit in bits 7:4 and its units digit in bits 3:0. With bcd_mode_i=0 it holds the plain binary value.
- R6: With h24_mode_i=1 the hour field holds 0 to 23. With h24_mode_i=0 it holds 1 to 12 in bits 6:0, where midnight and noon are both 12, and bit 7 is set for hours 12 to 23. On load, 12 without the flag decodes to hour 0 and 12 with the flag decodes to hour 12.
- R7: A strobe is accepted only when div_sel_i equals 3'b010 and no window is open. Strobes at any other divider code, or during an open window, change nothing.
- R8: While set_i=1, strobes start no window and field registers change only by host writes. wr_sel_i picks the field: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year. Writes with set_i=0 are ignored. On the cycle after set_i falls, the counter is loaded from the registers.
- R9: An accepted strobe raises uip_o in the next cycle and holds it for exactly UIP_CYCLES (8) cycles. The fields show the advanced time from the cycle in which uip_o falls.
- R10: done_o is high for exactly one cycle, the cycle in which uip_o has just fallen and the new values appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-second strobe |
| div_sel_i | input | 3 | Divider-select field; 3'b010 enables counting |
| bcd_mode_i | input | 1 | 1 = BCD register format, 0 = binary |
| h24_mode_i | input | 1 | 1 = 24-hour hours, 0 = 12-hour with afternoon flag |
| set_i | input | 1 | Halt counting and open fields to host writes |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 3 | Field select for host write |
| wr_data_i | input | 8 | Host write data in register format |
| sec_o | output | 8 | Seconds field |
| min_o | output | 8 | Minutes field |
| hour_o | output | 8 | Hours field |
| wday_o | output | 8 | Day-of-week field |
| mday_o | output | 8 | Day-of-month field |
| mon_o | output | 8 | Month field |
| year_o | output | 8 | Two-digit year field |
| uip_o | output | 1 | Update-in-progress window |
| done_o | output | 1 | Update-complete strobe |

## Verification
On every cycle the assertions check the timing behaviour:
- the window never runs longer than its set length;
- the done strobe lasts one cycle and only follows a closing window;
- a halted clock or a non-run divider code never opens a window;
- the halt input freezes the fields whenever no write is presented.

The calendar arithmetic can only be shown by the bench's scenarios. These cover month lengths in ordinary, leap and century years, the carries from second up to year, both number formats and the 12-hour encoding of every hour, and the load path through the host writes.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int NUM_FIELDS  = 7;
  localparam int FIELD_W     = 8;
  localparam int FLD_SEC     = 0;
  localparam int FLD_MIN     = 1;
  localparam int FLD_HOUR    = 2;
  localparam int FLD_WDAY    = 3;
  localparam int FLD_MDAY    = 4;
  localparam int FLD_MON     = 5;
  localparam int FLD_YEAR    = 6;

  localparam logic [2:0] RUN_CODE = 3'b010;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [4:0] hour;
    logic [2:0] wday;
    logic [4:0] mday;
    logic [3:0] mon;
    logic [6:0] year;
    logic [6:0] cent;
  } cal_t;

  // Full year = cent*100 + yy; cent*100 is always a multiple of 4,
  // so divisibility by 4 is decided by yy alone.
  function automatic logic is_leap(input logic [6:0] yy, input logic [6:0] cent);
    return (yy[1:0] == 2'd0) && ((yy != 7'd0) || (cent[1:0] == 2'd0));
  endfunction

  function automatic logic [4:0] month_len(input logic [3:0] mon,
                                           input logic [6:0] yy,
                                           input logic [6:0] cent);
    case (mon)
      4'd2:                      return is_leap(yy, cent) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

  function automatic logic [FIELD_W-1:0] reset_raw(input int idx,
                                                   input logic bcd,
                                                   input logic h24);
    case (idx)
      FLD_HOUR:                    return h24 ? 8'h00 : (bcd ? 8'h12 : 8'h0C);
      FLD_WDAY, FLD_MDAY, FLD_MON: return 8'h01;
      default:                     return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cal_fmt_enc.sv
module cal_fmt_enc #(
  parameter bit IS_HOUR = 1'b0
) (
  input  logic [6:0] bin_i,
  input  logic       bcd_mode_i,
  input  logic       h24_mode_i,
  output logic [7:0] raw_o
);
  logic       pm;
  logic [6:0] v;
  logic [7:0] body;

  always_comb begin
    pm = 1'b0;
    v  = bin_i;
    if (IS_HOUR && !h24_mode_i) begin
      pm = (bin_i >= 7'd12);
      v  = pm ? (bin_i - 7'd12) : bin_i;
      if (v == 7'd0) v = 7'd12;
    end
    if (bcd_mode_i)
      body = {4'(v / 7'd10), 4'(v % 7'd10)};
    else
      body = {1'b0, v};
    raw_o = {body[7] | pm, body[6:0]};
  end
endmodule

// File: rtl/cal_fmt_dec.sv
module cal_fmt_dec #(
  parameter bit IS_HOUR = 1'b0
) (
  input  logic [7:0] raw_i,
  input  logic       bcd_mode_i,
  input  logic       h24_mode_i,
  output logic [6:0] bin_o
);
  logic       twelve;
  logic       pm;
  logic [7:0] field;
  logic [6:0] v;

  always_comb begin
    twelve = IS_HOUR && !h24_mode_i;
    pm     = twelve && raw_i[7];
    field  = twelve ? {1'b0, raw_i[6:0]} : raw_i;
    if (bcd_mode_i)
      v = 7'(field[7:4] * 4'd10) + 7'(field[3:0]);
    else
      v = field[6:0];
    if (twelve) begin
      if (v == 7'd12) v = 7'd0;
      if (pm)         v = v + 7'd12;
    end
    bin_o = v;
  end
endmodule

// File: rtl/cal_time_core.sv
module cal_time_core
  import rtc_cal_pkg::*;
#(
  parameter int RESET_CENTURY = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  input  logic load_i,
  input  cal_t load_val_i,
  output cal_t now_o,
  output cal_t next_o
);
  cal_t       cur_q;
  cal_t       nxt;
  cal_t       ld;
  logic [4:0] mlen;

  assign mlen = month_len(cur_q.mon, cur_q.year, cur_q.cent);

  always_comb begin
    ld      = load_val_i;
    ld.cent = cur_q.cent;
  end

  always_comb begin
    nxt = cur_q;
    if (cur_q.sec >= 7'd59) begin
      nxt.sec = 7'd0;
      if (cur_q.min >= 7'd59) begin
        nxt.min = 7'd0;
        if (cur_q.hour >= 5'd23) begin
          nxt.hour = 5'd0;
          nxt.wday = (cur_q.wday >= 3'd7) ? 3'd1 : cur_q.wday + 3'd1;
          if (cur_q.mday >= mlen) begin
            nxt.mday = 5'd1;
            if (cur_q.mon >= 4'd12) begin
              nxt.mon = 4'd1;
              if (cur_q.year >= 7'd99) begin
                nxt.year = 7'd0;
                nxt.cent = (cur_q.cent >= 7'd99) ? 7'd0 : cur_q.cent + 7'd1;
              end else begin
                nxt.year = cur_q.year + 7'd1;
              end
            end else begin
              nxt.mon = cur_q.mon + 4'd1;
            end
          end else begin
            nxt.mday = cur_q.mday + 5'd1;
          end
        end else begin
          nxt.hour = cur_q.hour + 5'd1;
        end
      end else begin
        nxt.min = cur_q.min + 7'd1;
      end
    end else begin
      nxt.sec = cur_q.sec + 7'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q      <= '0;
      cur_q.wday <= 3'd1;
      cur_q.mday <= 5'd1;
      cur_q.mon  <= 4'd1;
      cur_q.cent <= 7'(RESET_CENTURY);
    end else if (load_i) begin
      cur_q <= ld;
    end else if (step_i) begin
      cur_q <= nxt;
    end
  end

  assign now_o  = cur_q;
  assign next_o = nxt;
endmodule

// File: rtl/rtc_calendar_counter.sv
module rtc_calendar_counter
  import rtc_cal_pkg::*;
#(
  parameter int UIP_CYCLES    = 8,
  parameter int RESET_CENTURY = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic [2:0] div_sel_i,
  input  logic       bcd_mode_i,
  input  logic       h24_mode_i,
  input  logic       set_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] mday_o,
  output logic [7:0] mon_o,
  output logic [7:0] year_o,
  output logic       uip_o,
  output logic       done_o
);
  localparam int UIP_W = (UIP_CYCLES > 1) ? $clog2(UIP_CYCLES) : 1;

  logic             uip_q, done_q, set_q;
  logic [UIP_W-1:0] cnt_q;
  logic             start, finish, step, load;
  cal_t             now_s, next_s, ld_val;

  logic [6:0]         next_bin [NUM_FIELDS];
  logic [6:0]         dec_bin  [NUM_FIELDS];
  logic [FIELD_W-1:0] field_q  [NUM_FIELDS];

  assign start  = tick_i && (div_sel_i == RUN_CODE) && !set_i && !uip_q;
  assign finish = uip_q && (cnt_q == '0);
  assign step   = finish && !set_i && !set_q;
  assign load   = set_q && !set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      uip_q  <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      set_q  <= 1'b0;
    end else begin
      set_q  <= set_i;
      done_q <= step;
      if (start) begin
        uip_q <= 1'b1;
        cnt_q <= UIP_W'(UIP_CYCLES - 1);
      end else if (uip_q) begin
        if (finish) uip_q <= 1'b0;
        else        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  cal_time_core #(.RESET_CENTURY(RESET_CENTURY)) u_core (
    .clk        (clk),
    .rst        (rst),
    .step_i     (step),
    .load_i     (load),
    .load_val_i (ld_val),
    .now_o      (now_s),
    .next_o     (next_s)
  );

  assign next_bin[FLD_SEC]  = next_s.sec;
  assign next_bin[FLD_MIN]  = next_s.min;
  assign next_bin[FLD_HOUR] = {2'b0, next_s.hour};
  assign next_bin[FLD_WDAY] = {4'b0, next_s.wday};
  assign next_bin[FLD_MDAY] = {2'b0, next_s.mday};
  assign next_bin[FLD_MON]  = {3'b0, next_s.mon};
  assign next_bin[FLD_YEAR] = next_s.year;

  always_comb begin
    ld_val      = now_s;
    ld_val.sec  = dec_bin[FLD_SEC];
    ld_val.min  = dec_bin[FLD_MIN];
    ld_val.hour = dec_bin[FLD_HOUR][4:0];
    ld_val.wday = dec_bin[FLD_WDAY][2:0];
    ld_val.mday = dec_bin[FLD_MDAY][4:0];
    ld_val.mon  = dec_bin[FLD_MON][3:0];
    ld_val.year = dec_bin[FLD_YEAR];
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    logic [FIELD_W-1:0] raw_next;
    logic [FIELD_W-1:0] fld_q;

    cal_fmt_enc #(.IS_HOUR(i == FLD_HOUR)) u_enc (
      .bin_i      (next_bin[i]),
      .bcd_mode_i (bcd_mode_i),
      .h24_mode_i (h24_mode_i),
      .raw_o      (raw_next)
    );

    cal_fmt_dec #(.IS_HOUR(i == FLD_HOUR)) u_dec (
      .raw_i      (fld_q),
      .bcd_mode_i (bcd_mode_i),
      .h24_mode_i (h24_mode_i),
      .bin_o      (dec_bin[i])
    );

    always_ff @(posedge clk) begin
      if (rst)
        fld_q <= reset_raw(i, bcd_mode_i, h24_mode_i);
      else if (step)
        fld_q <= raw_next;
      else if (set_i && wr_en_i && (wr_sel_i == 3'(i)))
        fld_q <= wr_data_i;
    end

    assign field_q[i] = fld_q;
  end

  assign sec_o  = field_q[FLD_SEC];
  assign min_o  = field_q[FLD_MIN];
  assign hour_o = field_q[FLD_HOUR];
  assign wday_o = field_q[FLD_WDAY];
  assign mday_o = field_q[FLD_MDAY];
  assign mon_o  = field_q[FLD_MON];
  assign year_o = field_q[FLD_YEAR];
  assign uip_o  = uip_q;
  assign done_o = done_q;
endmodule

// File: rtl/rtc_calendar_counter_chk.sv
module rtc_calendar_counter_chk #(
  parameter int UIP_CYCLES = 8
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] div_sel_i,
  input logic       set_i,
  input logic       wr_en_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] wday_o,
  input logic [7:0] mday_o,
  input logic [7:0] mon_o,
  input logic [7:0] year_o,
  input logic       uip_o,
  input logic       done_o
);
  int unsigned uip_run;

  always_ff @(posedge clk) begin
    if (rst)        uip_run <= 0;
    else if (uip_o) uip_run <= uip_run + 1;
    else            uip_run <= 0;
  end

  // R9: the window never stays open longer than UIP_CYCLES cycles
  a_r9_uip_bounded: assert property (@(posedge clk) disable iff (rst)
    uip_o |-> (uip_run < UIP_CYCLES));

  // R10: done only right after a window closes
  a_r10_done_after_uip: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(uip_o) && !uip_o));

  // R10: done lasts a single cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7: no window opens unless the divider holds the run code
  a_r7_halted_divider: assert property (@(posedge clk) disable iff (rst)
    (!uip_o && div_sel_i != 3'b010) |=> !uip_o);

  // R8: halt blocks new windows
  a_r8_set_no_window: assert property (@(posedge clk) disable iff (rst)
    (set_i && !uip_o) |=> !uip_o);

  // R8: halt without a write freezes every field
  a_r8_set_freezes: assert property (@(posedge clk) disable iff (rst)
    (set_i && !wr_en_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)
      && $stable(wday_o) && $stable(mday_o) && $stable(mon_o) && $stable(year_o)));
endmodule

bind rtc_calendar_counter rtc_calendar_counter_chk #(.UIP_CYCLES(UIP_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .div_sel_i (div_sel_i),
  .set_i     (set_i),
  .wr_en_i   (wr_en_i),
  .sec_o     (sec_o),
  .min_o     (min_o),
  .hour_o    (hour_o),
  .wday_o    (wday_o),
  .mday_o    (mday_o),
  .mon_o     (mon_o),
  .year_o    (year_o),
  .uip_o     (uip_o),
  .done_o    (done_o)
);

// File: tb/rtc_calendar_counter_tb.sv
`timescale 1ns/1ps
module rtc_calendar_counter_tb;
  localparam int UIP = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic [2:0] div_sel_i = 3'b010;
  logic       bcd_m = 1'b1;
  logic       h24_m = 1'b1;
  logic       set_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_sel_i = 3'd0;
  logic [7:0] wr_data_i = 8'd0;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;
  logic       uip_o, done_o;

  int checks = 0;
  int fails  = 0;
  int cent   = 20;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rtc_calendar_counter #(.UIP_CYCLES(UIP), .RESET_CENTURY(20)) u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .div_sel_i(div_sel_i),
    .bcd_mode_i(bcd_m), .h24_mode_i(h24_m), .set_i(set_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o),
    .uip_o(uip_o), .done_o(done_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int enc(input int v, input bit bcd);
    return bcd ? (((v / 10) << 4) | (v % 10)) : v;
  endfunction

  function automatic int enc_hour(input int h, input bit bcd, input bit h24);
    int h12;
    if (h24) return enc(h, bcd);
    h12 = h % 12;
    if (h12 == 0) h12 = 12;
    return enc(h12, bcd) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic int dim(input int m, input int yf);
    bit leap;
    leap = (yf % 4 == 0) && ((yf % 100 != 0) || (yf % 400 == 0));
    case (m)
      2:             return leap ? 29 : 28;
      4, 6, 9, 11:   return 30;
      default:       return 31;
    endcase
  endfunction

  task automatic write_field(input int idx, input int val);
    @(negedge clk);
    wr_en_i   = 1'b1;
    wr_sel_i  = 3'(idx);
    wr_data_i = 8'(val);
    @(negedge clk);
    wr_en_i   = 1'b0;
  endtask

  task automatic load_time(input int s, input int mi, input int h, input int wd,
                           input int d, input int mo, input int y);
    @(negedge clk);
    set_i = 1'b1;
    write_field(0, enc(s, bcd_m));
    write_field(1, enc(mi, bcd_m));
    write_field(2, enc_hour(h, bcd_m, h24_m));
    write_field(3, enc(wd, bcd_m));
    write_field(4, enc(d, bcd_m));
    write_field(5, enc(mo, bcd_m));
    write_field(6, enc(y, bcd_m));
    set_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_tick(output int len, output bit done_ok);
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    len = 0;
    while (uip_o && len < 100) begin
      len++;
      @(negedge clk);
    end
    done_ok = done_o;
    @(negedge clk);
    done_ok = done_ok && !done_o;
  endtask

  task automatic check_fields(input string req, input int s, input int mi, input int h,
                              input int wd, input int d, input int mo, input int y);
    chk(req, "sec",  sec_o,  enc(s, bcd_m));
    chk(req, "min",  min_o,  enc(mi, bcd_m));
    chk(req, "hour", hour_o, enc_hour(h, bcd_m, h24_m));
    chk(req, "wday", wday_o, enc(wd, bcd_m));
    chk(req, "mday", mday_o, enc(d, bcd_m));
    chk(req, "mon",  mon_o,  enc(mo, bcd_m));
    chk(req, "year", year_o, enc(y, bcd_m));
  endtask

  // Load a time, apply one strobe, compare against the arithmetic model.
  task automatic step_check(input string req, input int s, input int mi, input int h,
                            input int wd, input int d, input int mo, input int y);
    int es, em, eh, ew, ed, emo, ey, len;
    bit dn;
    es = s; em = mi; eh = h; ew = wd; ed = d; emo = mo; ey = y;
    es++;
    if (es == 60) begin
      es = 0; em++;
      if (em == 60) begin
        em = 0; eh++;
        if (eh == 24) begin
          eh = 0; ew = ew % 7 + 1; ed++;
          if (ed > dim(mo, cent * 100 + y)) begin
            ed = 1; emo++;
            if (emo == 13) begin
              emo = 1; ey++;
              if (ey == 100) begin ey = 0; cent++; end
            end
          end
        end
      end
    end
    load_time(s, mi, h, wd, d, mo, y);
    run_tick(len, dn);
    chk("R9", "uip width", len, UIP);
    chk("R10", "done pulse", int'(dn), 1);
    check_fields(req, es, em, eh, ew, ed, emo, ey);
  endtask

  initial begin
    int len;
    bit dn;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check_fields("R1", 0, 0, 0, 1, 1, 1, 0);
    chk("R1", "uip", uip_o, 0);
    chk("R1", "done", done_o, 0);

    // R3 / R4: last day of every month in ordinary, leap and century-leap years
    for (int yi = 0; yi < 3; yi++) begin
      int y;
      y = (yi == 0) ? 1 : (yi == 1) ? 4 : 0;
      for (int m = 1; m <= 12; m++)
        step_check("R3_R4", 59, 59, 23, (m % 7) + 1, dim(m, 2000 + y), m, y);
    end
    step_check("R3", 59, 59, 23, 3, 28, 2, 4);
    step_check("R3", 59, 59, 23, 3, 28, 2, 1);

    // R2: second and minute carries, day-of-week wrap
    step_check("R2", 12, 34, 5, 2, 10, 6, 7);
    step_check("R2", 59, 34, 5, 2, 10, 6, 7);
    step_check("R2", 59, 59, 5, 2, 10, 6, 7);
    step_check("R2", 59, 59, 23, 7, 10, 6, 7);

    // R6: every hour in 12-hour mode, BCD and binary
    h24_m = 1'b0;
    for (int b = 0; b < 2; b++) begin
      bcd_m = (b == 0);
      for (int h = 0; h < 24; h++)
        step_check("R6", 59, 59, h, 2, 10, 6, 5);
    end

    // R5: binary 24-hour format
    h24_m = 1'b1;
    bcd_m = 1'b0;
    for (int h = 0; h < 24; h += 5)
      step_check("R5", 59, 59, h, 4, 30, 4, 39);
    step_check("R5", 59, 59, 23, 4, 31, 12, 45);
    bcd_m = 1'b1;

    // R7: non-run divider codes ignore the strobe
    load_time(30, 20, 10, 3, 15, 5, 22);
    for (int c = 0; c < 8; c++) begin
      if (c == 2) continue;
      div_sel_i = 3'(c);
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
      chk("R7", "uip with halted divider", uip_o, 0);
      repeat (UIP + 2) @(negedge clk);
      chk("R7", "sec with halted divider", sec_o, enc(30, 1));
    end
    div_sel_i = 3'b010;

    // R7: a second strobe inside the window is ignored
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    repeat (3 * UIP) @(negedge clk);
    chk("R7", "one advance for two strobes", sec_o, enc(31, 1));
    chk("R7", "window closed", uip_o, 0);

    // R8: writes without halt are ignored
    write_field(0, 8'h45);
    @(negedge clk);
    chk("R8", "write ignored when running", sec_o, enc(31, 1));

    // R8: strobe while halted does nothing; halted writes land
    @(negedge clk); set_i = 1'b1;
    @(negedge clk); tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    chk("R8", "no window while halted", uip_o, 0);
    repeat (UIP + 2) @(negedge clk);
    chk("R8", "sec frozen while halted", sec_o, enc(31, 1));
    write_field(0, 8'h45);
    chk("R8", "halted write lands", sec_o, 8'h45);
    @(negedge clk); set_i = 1'b0;
    @(negedge clk);
    run_tick(len, dn);
    chk("R8", "counter loaded from written value", sec_o, enc(46, 1));
    chk("R10", "done after loaded step", int'(dn), 1);

    // R3 / R4: year wrap advances century to 21; 2100 is not a leap year
    step_check("R4", 59, 59, 23, 5, 31, 12, 99);
    chk("R3", "century advanced", cent, 21);
    step_check("R3", 59, 59, 23, 1, 28, 2, 0);
    chk("R3", "2100 March 1", mon_o, enc(3, 1));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule